// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes a single memory request from a warp of up to 32 lanes and turns it into the fewest possible line-sized memory transactions. Each lane presents an enable bit and a byte address. The block groups every enabled lane whose address falls into the same aligned 128-byte line, then emits one transaction per distinct line. Each transaction carries the line's base address and a mask of the lanes it serves.

A request is taken on a valid/ready handshake. Transactions leave one per cycle on a second valid/ready port, and the block holds each one until it is accepted. A single-cycle completion pulse follows the final transaction. The number of transactions depends only on how many distinct lines the enabled lanes touch. It does not depend on the lane count, and it does not depend on whether the addresses are ordered or crossed between lanes. Returning data to lanes, caching and memory timing belong to other blocks.

Top module: `warp_coalescer`

## Requirements
- R1: `req_ready` is high only when no transaction is outstanding. A request is taken when `req_valid` and `req_ready` are both high. After a request with at least one enabled lane is taken, `req_ready` stays low until the cycle of the `done` pulse.
- R2: `txn_line` is the byte address of the served lanes with its low 7 bits cleared, so it is always a multiple of 128.
- R3: A request produces exactly as many transactions as the number of distinct 128-byte lines touched by its enabled lanes. The addresses of lanes whose `req_active` bit is 0 have no effect on any transaction.
- R4: Each transaction serves the line of the lowest-numbered enabled lane that no earlier transaction of the same request has served.
- R5: Bit i of `txn_mask` is 1 exactly when lane i is enabled and its address lies in the line given by `txn_line`.
- R6: While `txn_valid` is high and `txn_ready` is low, `txn_valid`, `txn_line` and `txn_mask` stay unchanged in the next cycle.
- R7: `done` goes high for one cycle, in the cycle after the final transaction's handshake. In that cycle `txn_valid` is low.
- R8: A request with no enabled lanes issues no transaction. `done` goes high in the cycle after that request is taken.
- R9: A run of 32 consecutive 4-byte lane addresses that starts off a line boundary produces two transactions. The same run started on a boundary produces one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A warp request is presented |
| req_ready | output | 1 | Block can take a request |
| req_active | input | LANES | Per-lane enable, bit i for lane i |
| req_addr | input | LANES*ADDR_W | Lane byte addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| txn_valid | output | 1 | A transaction is presented |
| txn_ready | input | 1 | Memory side takes the transaction |
| txn_line | output | ADDR_W | Aligned base address of the line |
| txn_mask | output | LANES | Lanes served by this line |
| done | output | 1 | One-cycle pulse after the request completes |

## Verification
The bench goes after several corner cases:
- A contiguous run started 8 bytes before a boundary. A design that counted lanes, or that took the first address as the line base, would emit one transaction instead of two.
- A descending address pattern and a sparse lane pattern, which catch designs that assume address order or lane contiguity.
- Junk addresses on disabled lanes. A coalescer that forgot the enable bits would emit extra lines for them.
- A request with no enabled lanes. A design that waited for a transaction would never pulse `done`.
- Back-pressure on the transaction port, with a second request offered meanwhile. A wrong design would drop or change a held transaction, or would take the second request early.

// File: rtl/coal_pkg.sv
package coal_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } coal_state_e;

endpackage

// File: rtl/coal_lane_store.sv
module coal_lane_store #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [LANES-1:0]         act_in,
  input  logic [LANES*ADDR_W-1:0]  addr_in,
  input  logic                     clr_en,
  input  logic [LANES-1:0]         clr_mask,
  output logic [LANES-1:0]         pending,
  output logic [LANES*ADDR_W-1:0]  addr_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= '0;
      addr_q  <= '0;
    end else if (load) begin
      pending <= act_in;
      addr_q  <= addr_in;
    end else if (clr_en) begin
      pending <= pending & ~clr_mask;
    end
  end

endmodule

// File: rtl/coal_leader.sv
module coal_leader #(
  parameter int LANES = 32,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0] pending,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pending[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/coal_line_match.sv
module coal_line_match #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 7,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES*ADDR_W-1:0] addr_q,
  input  logic [LANES-1:0]        pending,
  input  logic [IDX_W-1:0]        lead_idx,
  output logic [ADDR_W-1:0]       lead_line,
  output logic [LANES-1:0]        match
);

  function automatic logic [ADDR_W-1:0] line_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  logic [ADDR_W-1:0] lead_addr;

  assign lead_addr = addr_q[lead_idx*ADDR_W +: ADDR_W];
  assign lead_line = line_base(lead_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [ADDR_W-1:0] lane_line;
    assign lane_line = line_base(addr_q[g*ADDR_W +: ADDR_W]);
    assign match[g]  = pending[g] && (lane_line == lead_line);
  end

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int LANES      = 32,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES-1:0]        req_active,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  output logic                    txn_valid,
  input  logic                    txn_ready,
  output logic [ADDR_W-1:0]       txn_line,
  output logic [LANES-1:0]        txn_mask,
  output logic                    done
);

  coal_state_e             state_q;
  logic                    done_q;
  logic [LANES-1:0]        pending;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic                    leader_found;
  logic [IDX_W-1:0]        leader_idx;
  logic [LANES-1:0]        match;

  // named internal events
  logic                    req_accept;
  logic                    req_empty;
  logic                    txn_fire;
  logic                    txn_final;
  logic [LANES-1:0]        rest_mask;

  assign req_ready  = (state_q == ST_IDLE);
  assign req_accept = req_valid && req_ready;
  assign req_empty  = (req_active == '0);
  assign txn_valid  = (state_q == ST_BUSY) && leader_found;
  assign txn_mask   = match;
  assign txn_fire   = txn_valid && txn_ready;
  assign rest_mask  = pending & ~match;
  assign txn_final  = txn_fire && (rest_mask == '0);
  assign done       = done_q;

  coal_lane_store #(.LANES(LANES), .ADDR_W(ADDR_W)) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (req_accept),
    .act_in   (req_active),
    .addr_in  (req_addr),
    .clr_en   (txn_fire),
    .clr_mask (match),
    .pending  (pending),
    .addr_q   (addr_q)
  );

  coal_leader #(.LANES(LANES)) leader_i (
    .pending (pending),
    .found   (leader_found),
    .idx     (leader_idx)
  );

  coal_line_match #(.LANES(LANES), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) match_i (
    .addr_q    (addr_q),
    .pending   (pending),
    .lead_idx  (leader_idx),
    .lead_line (txn_line),
    .match     (match)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= (req_accept && req_empty) || txn_final;
      if (req_accept) begin
        state_q <= req_empty ? ST_IDLE : ST_BUSY;
      end else if (txn_final) begin
        state_q <= ST_IDLE;
      end
    end
  end

endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 7,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LANES-1:0]  req_active,
  input logic              txn_valid,
  input logic              txn_ready,
  input logic [ADDR_W-1:0] txn_line,
  input logic [LANES-1:0]  txn_mask,
  input logic              done,
  input logic [IDX_W-1:0]  leader_idx,
  input logic [LANES-1:0]  pending
);

  a_r1_busy_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> !req_ready);

  a_r2_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_line[OFF_W-1:0] == '0));

  a_r3_served_lanes_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_ready) |=> ((pending & $past(txn_mask)) == '0));

  a_r4_leader_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> txn_mask[leader_idx]);

  a_r5_mask_within_pending: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((txn_mask & ~pending) == '0));

  a_r6_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_line) && $stable(txn_mask)));

  a_r7_done_no_txn: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !txn_valid);

  a_r8_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_active == '0)) |=> done);

endmodule

bind warp_coalescer coal_checker #(.LANES(LANES), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_active (req_active),
  .txn_valid  (txn_valid),
  .txn_ready  (txn_ready),
  .txn_line   (txn_line),
  .txn_mask   (txn_mask),
  .done       (done),
  .leader_idx (leader_idx),
  .pending    (pending)
);

// File: tb/warp_coalescer_tb.sv
module warp_coalescer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 32;
  localparam int ADDR_W = 32;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    req_valid = 1'b0;
  logic                    req_ready;
  logic [LANES-1:0]        req_active = '0;
  logic [LANES*ADDR_W-1:0] req_addr = '0;
  logic                    txn_valid;
  logic                    txn_ready = 1'b1;
  logic [ADDR_W-1:0]       txn_line;
  logic [LANES-1:0]        txn_mask;
  logic                    done;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_coalescer dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_active(req_active), .req_addr(req_addr), .txn_valid(txn_valid),
    .txn_ready(txn_ready), .txn_line(txn_line), .txn_mask(txn_mask), .done(done)
  );

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] stride;
    logic [31:0] act;
    logic [7:0]  lines;
  } vec_t;

  // lane i address = base + i*stride; disabled lanes carry junk
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 32'd4,        32'hFFFF_FFFF, 8'd1},   // aligned run
    '{32'h0000_0078, 32'd4,        32'hFFFF_FFFF, 8'd2},   // run off boundary
    '{32'h0000_0000, 32'd8,        32'hFFFF_FFFF, 8'd2},
    '{32'h0000_0000, 32'd128,      32'hFFFF_FFFF, 8'd32},
    '{32'h0000_1000, 32'd0,        32'hFFFF_FFFF, 8'd1},   // broadcast
    '{32'h0000_0000, 32'd4,        32'h0000_FFFF, 8'd1},   // junk on off lanes
    '{32'h0000_0000, 32'd128,      32'h0000_0000, 8'd0},   // empty
    '{32'h0000_0040, 32'd64,       32'hF0F0_F0F0, 8'd12},  // sparse
    '{32'h0000_0200, 32'hFFFF_FFFC, 32'hFFFF_FFFF, 8'd2}   // descending
  };

  logic [ADDR_W-1:0] exp_line [LANES];
  logic [LANES-1:0]  exp_mask [LANES];
  int                exp_n;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive_req(input logic [31:0] base, input logic [31:0] stride,
                           input logic [31:0] act);
    req_active = act;
    for (int i = 0; i < LANES; i++) begin
      if (act[i]) req_addr[i*ADDR_W +: ADDR_W] = base + stride * 32'(i);
      else        req_addr[i*ADDR_W +: ADDR_W] = 32'hDEAD_0000 + 32'(i) * 32'h0001_0300;
    end
  endtask

  // model: list distinct line numbers in lane order
  task automatic build_model();
    exp_n = 0;
    for (int i = 0; i < LANES; i++) begin
      if (req_active[i]) begin
        logic [ADDR_W-8:0] key;
        bit seen;
        key  = req_addr[i*ADDR_W + 7 +: ADDR_W-7];
        seen = 0;
        for (int k = 0; k < exp_n; k++) begin
          if (exp_line[k] == {key, 7'b0}) begin
            seen = 1;
            exp_mask[k][i] = 1'b1;
          end
        end
        if (!seen) begin
          exp_line[exp_n] = {key, 7'b0};
          exp_mask[exp_n] = '0;
          exp_mask[exp_n][i] = 1'b1;
          exp_n++;
        end
      end
    end
  endtask

  task automatic run_request(input logic [31:0] base, input logic [31:0] stride,
                             input logic [31:0] act, input int want_lines);
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready when idle", 64'(req_ready), 64'd1);
    drive_req(base, stride, act);
    build_model();
    check(exp_n == want_lines, "R3", "distinct line count", 64'(exp_n), 64'(want_lines));
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < exp_n; k++) begin
      check(txn_valid == 1'b1, "R3", "txn present", 64'(txn_valid), 64'd1);
      check(txn_line == exp_line[k], "R2/R4", "txn line", 64'(txn_line), 64'(exp_line[k]));
      check(txn_mask == exp_mask[k], "R5", "txn mask", 64'(txn_mask), 64'(exp_mask[k]));
      check(req_ready == 1'b0, "R1", "ready low while busy", 64'(req_ready), 64'd0);
      @(posedge clk);
      @(negedge clk);
    end
    if (exp_n == 0)
      check(done == 1'b1, "R8", "empty request done", 64'(done), 64'd1);
    else
      check(done == 1'b1, "R7", "done after last txn", 64'(done), 64'd1);
    check(txn_valid == 1'b0, "R7", "no txn beyond count", 64'(txn_valid), 64'd0);
    @(negedge clk);
    check(done == 1'b0, "R7", "done is one cycle", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, got 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "reset ready", 64'(req_ready), 64'd1);
    check(txn_valid == 1'b0, "R7", "reset txn_valid", 64'(txn_valid), 64'd0);
    check(done == 1'b0, "R7", "reset done", 64'(done), 64'd0);
    rst_n = 1'b1;

    // table walk: R3 count, R9 boundary runs, R8 empty
    for (int v = 0; v < NV; v++) begin
      run_request(VECS[v].base, VECS[v].stride, VECS[v].act, int'(VECS[v].lines));
    end

    // R6 stall with R1 second request offered while busy
    @(negedge clk);
    txn_ready = 1'b0;
    drive_req(32'h0000_0000, 32'd128, 32'h0000_0007);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    drive_req(32'h0000_4000, 32'd0, 32'hFFFF_FFFF);
    for (int c = 0; c < 3; c++) begin
      check(txn_valid == 1'b1, "R6", "held valid", 64'(txn_valid), 64'd1);
      check(txn_line == 32'h0, "R6", "held line", 64'(txn_line), 64'h0);
      check(txn_mask == 32'h1, "R6", "held mask", 64'(txn_mask), 64'h1);
      check(req_ready == 1'b0, "R1", "second request refused", 64'(req_ready), 64'd0);
      @(posedge clk);
      @(negedge clk);
    end
    req_valid = 1'b0;
    txn_ready = 1'b1;
    for (int k = 0; k < 3; k++) begin
      check(txn_line == 32'(k * 128), "R4", "line after stall", 64'(txn_line), 64'(k * 128));
      check(txn_mask == 32'(1 << k), "R5", "mask after stall", 64'(txn_mask), 64'(1 << k));
      @(posedge clk);
      @(negedge clk);
    end
    check(done == 1'b1, "R7", "done after stalled request", 64'(done), 64'd1);
    check(txn_valid == 1'b0, "R1", "refused request left no txn", 64'(txn_valid), 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule